// File: doc/BRIEF.md
# ECAM Configuration Access Router

The router takes 32-bit memory-mapped configuration accesses from a hart and turns each one into a configuration request for one PCIe root port. It splits the ECAM offset into bus, device, function and register fields. It then compares the bus number with the primary, secondary and subordinate bus numbers that the root port holds. From that comparison it either issues a type 0 request, issues a type 1 request, passes the access to the root port's own register file, or finishes the access inside the block.

An access that nothing can answer never stalls the request port. A read of that kind returns all-ones data, and a write of that kind is retired without effect. This covers a misaligned offset, a bus outside the hierarchy, a missing function on the primary bus, and a device filtered out while ARI forwarding is off.

Remote completions pass through to the hart. Failure statuses are turned into all-ones read data. The poison marking is forwarded unless software has disabled forwarding. A configuration-retry status re-issues the request, up to a programmed number of times. Only one access is in flight at a time.

Top module: `ecam_cfg_router`

## Requirements
- R1: The offset on `req_addr` is split as bus [27:20], device [19:15], function [14:12] and byte offset [11:0]. A forwarded request carries the bus, device and function unchanged and carries the dword index (byte offset bits [11:2]) on `cq_reg`, together with the write flag and the write data. While `cq_ready` is low, these fields stay stable.
- R2: An aligned access whose bus equals `cfg_secondary` (and not `cfg_primary`) is issued with `cq_type1` = 0, provided the ARI filter of R6 does not apply.
- R3: An aligned access whose bus is greater than `cfg_secondary` and not greater than `cfg_subordinate` (and not equal to `cfg_primary`) is issued with `cq_type1` = 1.
- R4: An aligned access to `cfg_primary` with device 0 and function 0 raises `own_valid` in its acceptance cycle. In that cycle `own_write` equals the write flag, `own_reg` equals the dword index and `own_wdata` equals the write data. A read answers with the `own_rdata` sampled in that cycle. Any other device or function on the primary bus is completed locally, with no request issued.
- R5: An aligned access whose bus matches none of the rules above is completed locally and issues no request. A local completion sets `rsp_valid` in the cycle after acceptance, with `rsp_rdata` = 0xFFFFFFFF for a read. Every write response carries `rsp_rdata` = 0 and `rsp_poison` = 0.
- R6: When `cfg_ari_fwd_en` = 0, an access to the secondary bus with a nonzero device is completed locally: reads return all-ones and writes are dropped. When `cfg_ari_fwd_en` = 1, such an access is issued as type 0.
- R7: An access with `req_addr[1:0]` not equal to 0 is completed locally, whatever its bus number.
- R8: `cc_status` is encoded as 0 = success, 1 = unsupported, 2 = configuration retry, 3 = abort. A read completing with status 1 or 3 returns all-ones. A write completing with status 1 or 3 is still acknowledged.
- R9: A successful read completion with `cc_poison` = 1 returns `cc_data` with `rsp_poison` = 1. If `cfg_poison_fwd_dis` = 1, it instead returns all-ones with `rsp_poison` = 0.
- R10: A retry status re-issues the same request, up to `cfg_retry_limit` extra times per access. A retry status that arrives after the limit is reached completes the access: a read returns all-ones and a write is dropped.
- R11: `req_ready` is high only when no access is in flight. `cq_valid` is never high at the same time as `req_ready`. `rsp_valid` is a single-cycle pulse.
- R12: After reset, `req_ready` = 1, `cq_valid` = 0 and `rsp_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Hart access present |
| req_ready | output | 1 | Router can accept an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 28 | ECAM offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response pulse to the hart |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| rsp_poison | output | 1 | Read data is poisoned |
| cfg_primary | input | 8 | Primary bus number |
| cfg_secondary | input | 8 | Secondary bus number |
| cfg_subordinate | input | 8 | Subordinate bus number |
| cfg_ari_fwd_en | input | 1 | ARI forwarding enabled |
| cfg_poison_fwd_dis | input | 1 | Do not forward poisoned data |
| cfg_retry_limit | input | 4 | Extra issues allowed after a retry status |
| own_valid | output | 1 | Access to the root port's own registers |
| own_write | output | 1 | Own-register write |
| own_reg | output | 10 | Own-register dword index |
| own_wdata | output | 32 | Own-register write data |
| own_rdata | input | 32 | Own-register read data, same cycle |
| cq_valid | output | 1 | Configuration request valid |
| cq_ready | input | 1 | Request accepted by the requester |
| cq_type1 | output | 1 | 1 = type 1, 0 = type 0 |
| cq_write | output | 1 | Request is a write |
| cq_bus | output | 8 | Target bus |
| cq_dev | output | 5 | Target device |
| cq_func | output | 3 | Target function |
| cq_reg | output | 10 | Target dword index |
| cq_wdata | output | 32 | Request write data |
| cc_valid | input | 1 | Completion present |
| cc_status | input | 2 | Completion status |
| cc_data | input | 32 | Completion data |
| cc_poison | input | 1 | Completion poisoned |

## Verification
The bus-range and poison properties assume that the bus-number, ARI and poison-control inputs hold still while an access is in flight. The bench changes them only between accesses. The properties also assume that the requester sends exactly one completion per accepted request, and only after the handshake. The bench's responder keeps to this by answering each accepted request once, one cycle after `cq_ready`.

// File: rtl/ecam_pkg.sv
package ecam_pkg;

    localparam int DATA_W  = 32;
    localparam int BUS_W   = 8;
    localparam int DEV_W   = 5;
    localparam int FN_W    = 3;
    localparam int OFS_W   = 12;
    localparam int DW_W    = OFS_W - 2;
    localparam int FN_LSB  = OFS_W;
    localparam int DEV_LSB = FN_LSB + FN_W;
    localparam int BUS_LSB = DEV_LSB + DEV_W;
    localparam int ADDR_W  = BUS_LSB + BUS_W;

    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    typedef enum logic [1:0] {
        ROUTE_LOCAL = 2'd0,
        ROUTE_OWN   = 2'd1,
        ROUTE_TYPE0 = 2'd2,
        ROUTE_TYPE1 = 2'd3
    } route_e;

    typedef enum logic [1:0] {
        CPL_OK    = 2'd0,
        CPL_UNSUP = 2'd1,
        CPL_RETRY = 2'd2,
        CPL_ABORT = 2'd3
    } cpl_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic [BUS_W-1:0] bus;
        logic [DEV_W-1:0] dev;
        logic [FN_W-1:0]  fn;
        logic [DW_W-1:0]  dw;
    } cfg_tgt_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              poison;
    } hrsp_t;

    function automatic cfg_tgt_t split_offset(input logic [ADDR_W-1:0] a);
        cfg_tgt_t t;
        t.bus = a[BUS_LSB +: BUS_W];
        t.dev = a[DEV_LSB +: DEV_W];
        t.fn  = a[FN_LSB  +: FN_W];
        t.dw  = a[2 +: DW_W];
        return t;
    endfunction

    function automatic hrsp_t local_reply(input logic is_write);
        hrsp_t r;
        r.data   = is_write ? '0 : ALL_ONES;
        r.poison = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/ecam_decode.sv
module ecam_decode
    import ecam_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  primary,
    input  logic [BUS_W-1:0]  secondary,
    input  logic [BUS_W-1:0]  subordinate,
    input  logic              ari_fwd_en,
    output cfg_tgt_t          tgt,
    output route_e            route
);

    logic misaligned;
    logic on_primary;
    logic on_secondary;
    logic below_sub;
    logic root_fn;
    logic ari_block;

    always_comb begin
        tgt          = split_offset(addr);
        misaligned   = (addr[1:0] != 2'b00);
        on_primary   = (tgt.bus == primary);
        on_secondary = (tgt.bus == secondary);
        below_sub    = (tgt.bus > secondary) && (tgt.bus <= subordinate);
        root_fn      = (tgt.dev == '0) && (tgt.fn == '0);
        ari_block    = !ari_fwd_en && (tgt.dev != '0);
    end

    always_comb begin
        if (misaligned) begin
            route = ROUTE_LOCAL;
        end else if (on_primary) begin
            route = root_fn ? ROUTE_OWN : ROUTE_LOCAL;
        end else if (on_secondary) begin
            route = ari_block ? ROUTE_LOCAL : ROUTE_TYPE0;
        end else if (below_sub) begin
            route = ROUTE_TYPE1;
        end else begin
            route = ROUTE_LOCAL;
        end
    end

endmodule

// File: rtl/ecam_cpl_fmt.sv
module ecam_cpl_fmt
    import ecam_pkg::*;
(
    input  logic              is_write,
    input  logic [1:0]        status,
    input  logic [DATA_W-1:0] data,
    input  logic              poison,
    input  logic              poison_fwd_dis,
    input  logic              retries_spent,
    output logic              retry_again,
    output hrsp_t             rsp
);

    cpl_e st;

    always_comb begin
        st          = cpl_e'(status);
        retry_again = (st == CPL_RETRY) && !retries_spent;
        rsp         = local_reply(is_write);
        if (!is_write) begin
            unique case (st)
                CPL_OK: begin
                    if (poison && poison_fwd_dis) begin
                        rsp.data   = ALL_ONES;
                        rsp.poison = 1'b0;
                    end else begin
                        rsp.data   = data;
                        rsp.poison = poison;
                    end
                end
                default: begin
                    rsp.data   = ALL_ONES;
                    rsp.poison = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/ecam_seq.sv
module ecam_seq
    import ecam_pkg::*;
#(
    parameter int RETRY_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [DATA_W-1:0]  req_wdata,
    input  cfg_tgt_t           tgt,
    input  route_e             route,
    input  logic [DATA_W-1:0]  own_rdata,
    input  logic [RETRY_W-1:0] retry_limit,
    input  logic               cq_ready,
    input  logic               cc_valid,
    input  logic               retry_again,
    input  hrsp_t              cpl_rsp,
    output logic               req_ready,
    output logic               own_valid,
    output logic               cq_valid,
    output logic               cq_type1,
    output logic               cur_write,
    output cfg_tgt_t           cur_tgt,
    output logic [DATA_W-1:0]  cur_wdata,
    output logic               retries_spent,
    output logic               rsp_valid,
    output hrsp_t              rsp
);

    seq_state_e         state;
    logic [RETRY_W-1:0] retry_cnt;
    logic               accept;

    always_comb begin
        req_ready     = (state == ST_IDLE);
        accept        = req_ready && req_valid;
        own_valid     = accept && (route == ROUTE_OWN);
        cq_valid      = (state == ST_ISSUE);
        rsp_valid     = (state == ST_RESP);
        retries_spent = (retry_cnt >= retry_limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            retry_cnt <= '0;
            cq_type1  <= 1'b0;
            cur_write <= 1'b0;
            cur_tgt   <= '0;
            cur_wdata <= '0;
            rsp       <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur_write <= req_write;
                        cur_tgt   <= tgt;
                        cur_wdata <= req_wdata;
                        retry_cnt <= '0;
                        cq_type1  <= (route == ROUTE_TYPE1);
                        unique case (route)
                            ROUTE_LOCAL: begin
                                rsp   <= local_reply(req_write);
                                state <= ST_RESP;
                            end
                            ROUTE_OWN: begin
                                rsp.data   <= req_write ? '0 : own_rdata;
                                rsp.poison <= 1'b0;
                                state      <= ST_RESP;
                            end
                            default: begin
                                state <= ST_ISSUE;
                            end
                        endcase
                    end
                end
                ST_ISSUE: begin
                    if (cq_ready) begin
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (cc_valid) begin
                        if (retry_again) begin
                            retry_cnt <= retry_cnt + 1'b1;
                            state     <= ST_ISSUE;
                        end else begin
                            rsp   <= cpl_rsp;
                            state <= ST_RESP;
                        end
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/ecam_cfg_router.sv
module ecam_cfg_router
    import ecam_pkg::*;
#(
    parameter int RETRY_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               rsp_poison,
    input  logic [BUS_W-1:0]   cfg_primary,
    input  logic [BUS_W-1:0]   cfg_secondary,
    input  logic [BUS_W-1:0]   cfg_subordinate,
    input  logic               cfg_ari_fwd_en,
    input  logic               cfg_poison_fwd_dis,
    input  logic [RETRY_W-1:0] cfg_retry_limit,
    output logic               own_valid,
    output logic               own_write,
    output logic [DW_W-1:0]    own_reg,
    output logic [DATA_W-1:0]  own_wdata,
    input  logic [DATA_W-1:0]  own_rdata,
    output logic               cq_valid,
    input  logic               cq_ready,
    output logic               cq_type1,
    output logic               cq_write,
    output logic [BUS_W-1:0]   cq_bus,
    output logic [DEV_W-1:0]   cq_dev,
    output logic [FN_W-1:0]    cq_func,
    output logic [DW_W-1:0]    cq_reg,
    output logic [DATA_W-1:0]  cq_wdata,
    input  logic               cc_valid,
    input  logic [1:0]         cc_status,
    input  logic [DATA_W-1:0]  cc_data,
    input  logic               cc_poison
);

    cfg_tgt_t dec_tgt;
    route_e   dec_route;
    cfg_tgt_t cur_tgt;
    hrsp_t    cpl_rsp;
    hrsp_t    out_rsp;
    logic     retry_again;
    logic     retries_spent;

    ecam_decode u_decode (
        .addr        (req_addr),
        .primary     (cfg_primary),
        .secondary   (cfg_secondary),
        .subordinate (cfg_subordinate),
        .ari_fwd_en  (cfg_ari_fwd_en),
        .tgt         (dec_tgt),
        .route       (dec_route)
    );

    ecam_cpl_fmt u_fmt (
        .is_write       (cq_write),
        .status         (cc_status),
        .data           (cc_data),
        .poison         (cc_poison),
        .poison_fwd_dis (cfg_poison_fwd_dis),
        .retries_spent  (retries_spent),
        .retry_again    (retry_again),
        .rsp            (cpl_rsp)
    );

    ecam_seq #(.RETRY_W(RETRY_W)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_wdata     (req_wdata),
        .tgt           (dec_tgt),
        .route         (dec_route),
        .own_rdata     (own_rdata),
        .retry_limit   (cfg_retry_limit),
        .cq_ready      (cq_ready),
        .cc_valid      (cc_valid),
        .retry_again   (retry_again),
        .cpl_rsp       (cpl_rsp),
        .req_ready     (req_ready),
        .own_valid     (own_valid),
        .cq_valid      (cq_valid),
        .cq_type1      (cq_type1),
        .cur_write     (cq_write),
        .cur_tgt       (cur_tgt),
        .cur_wdata     (cq_wdata),
        .retries_spent (retries_spent),
        .rsp_valid     (rsp_valid),
        .rsp           (out_rsp)
    );

    always_comb begin
        own_write  = req_write;
        own_reg    = dec_tgt.dw;
        own_wdata  = req_wdata;
        cq_bus     = cur_tgt.bus;
        cq_dev     = cur_tgt.dev;
        cq_func    = cur_tgt.fn;
        cq_reg     = cur_tgt.dw;
        rsp_rdata  = out_rsp.data;
        rsp_poison = out_rsp.poison;
    end

endmodule

// File: rtl/ecam_cfg_router_chk.sv
module ecam_cfg_router_chk
    import ecam_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             rsp_poison,
    input logic [BUS_W-1:0] cfg_secondary,
    input logic [BUS_W-1:0] cfg_subordinate,
    input logic             cfg_ari_fwd_en,
    input logic             cfg_poison_fwd_dis,
    input logic             own_valid,
    input logic             cq_valid,
    input logic             cq_ready,
    input logic             cq_type1,
    input logic [BUS_W-1:0] cq_bus,
    input logic [DEV_W-1:0] cq_dev,
    input logic [DW_W-1:0]  cq_reg
);

    p_single_outstanding_r11: assert property (@(posedge clk) disable iff (rst)
        cq_valid |-> !req_ready);

    p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    p_req_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (cq_valid && !cq_ready) |=> (cq_valid && $stable(cq_bus) && $stable(cq_dev)
                                     && $stable(cq_reg) && $stable(cq_type1)));

    p_type0_bus_r2: assert property (@(posedge clk) disable iff (rst)
        (cq_valid && !cq_type1) |-> (cq_bus == cfg_secondary));

    p_type1_bus_r3: assert property (@(posedge clk) disable iff (rst)
        (cq_valid && cq_type1) |-> ((cq_bus > cfg_secondary) && (cq_bus <= cfg_subordinate)));

    p_own_accept_r4: assert property (@(posedge clk) disable iff (rst)
        own_valid |-> (req_valid && req_ready));

    p_ari_filter_r6: assert property (@(posedge clk) disable iff (rst)
        (cq_valid && !cq_type1 && !cfg_ari_fwd_en) |-> (cq_dev == '0));

    p_poison_block_r9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && cfg_poison_fwd_dis) |-> !rsp_poison);

endmodule

bind ecam_cfg_router ecam_cfg_router_chk u_chk (.*);

// File: tb/tb_ecam_cfg_router.sv
`timescale 1ns/1ps
module tb_ecam_cfg_router;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [27:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_poison;
    logic [7:0]  cfg_primary = 8'd0;
    logic [7:0]  cfg_secondary = 8'd1;
    logic [7:0]  cfg_subordinate = 8'd4;
    logic        cfg_ari_fwd_en = 1'b0;
    logic        cfg_poison_fwd_dis = 1'b0;
    logic [3:0]  cfg_retry_limit = 4'd2;
    logic        own_valid;
    logic        own_write;
    logic [9:0]  own_reg;
    logic [31:0] own_wdata;
    logic [31:0] own_rdata;
    logic        cq_valid;
    logic        cq_ready = 1'b0;
    logic        cq_type1;
    logic        cq_write;
    logic [7:0]  cq_bus;
    logic [4:0]  cq_dev;
    logic [2:0]  cq_func;
    logic [9:0]  cq_reg;
    logic [31:0] cq_wdata;
    logic        cc_valid = 1'b0;
    logic [1:0]  cc_status = 2'd0;
    logic [31:0] cc_data = '0;
    logic        cc_poison = 1'b0;

    int checks = 0;
    int errors = 0;
    int mon_errors = 0;
    int cycles = 0;
    bit allow_req = 1'b0;

    always #10 clk = ~clk;

    assign own_rdata = 32'hA500_0000 | {22'd0, own_reg};

    ecam_cfg_router dut (.*);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + mon_errors + 1);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (!rst && cq_valid && !allow_req) begin
            mon_errors <= mon_errors + 1;
            $display("FAIL R5 monitor: request on bus %0d, actual cq_valid=1 expected 0", cq_bus);
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // route: 0 local, 1 own, 2 type0, 3 type1
    function automatic int exp_route(input int bus, input int dev, input int fn, input int off);
        if ((off % 4) != 0) return 0;
        if (bus == int'(cfg_primary)) return (dev == 0 && fn == 0) ? 1 : 0;
        if (bus == int'(cfg_secondary)) return (!cfg_ari_fwd_en && dev != 0) ? 0 : 2;
        if (bus > int'(cfg_secondary) && bus <= int'(cfg_subordinate)) return 3;
        return 0;
    endfunction

    task automatic xact(input bit wr, input int bus, input int dev, input int fn, input int off,
                        input logic [31:0] wd, input int n_rrs, input logic [1:0] fin_sts,
                        input logic [31:0] cdata, input bit cpois, input int rdy_dly,
                        input string tag);
        int route;
        int lim;
        int exp_issues;
        int issues;
        int phase;
        int dly;
        bit got;
        bit busy_ok;
        int lat;
        logic [31:0] exp_data;
        bit exp_pois;
        logic [31:0] got_data;
        bit got_pois;
        route = exp_route(bus, dev, fn, off);
        lim = int'(cfg_retry_limit);
        exp_pois = 1'b0;
        if (route >= 2) exp_issues = ((n_rrs < lim) ? n_rrs : lim) + 1;
        else exp_issues = 0;
        if (wr) exp_data = 32'h0;
        else if (route == 0) exp_data = 32'hFFFF_FFFF;
        else if (route == 1) exp_data = 32'hA500_0000 | (off >> 2);
        else if (n_rrs > lim) exp_data = 32'hFFFF_FFFF;
        else if (fin_sts != 2'd0) exp_data = 32'hFFFF_FFFF;
        else if (cpois && cfg_poison_fwd_dis) exp_data = 32'hFFFF_FFFF;
        else begin exp_data = cdata; exp_pois = cpois; end
        allow_req = (route >= 2);

        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr = 28'((bus << 20) | (dev << 15) | (fn << 12) | off);
        req_wdata = wd;
        #1;
        check(req_ready == 1'b1, {tag, " R11 ready when idle"}, {31'd0, req_ready}, 32'd1);
        check(own_valid == (route == 1), {tag, " R4 own_valid"}, {31'd0, own_valid}, {31'd0, route == 1});
        if (route == 1)
            check(own_write == wr && own_reg == 10'(off >> 2) && own_wdata == wd,
                  {tag, " R4 own fields"}, {21'd0, own_write, own_reg}, {21'd0, wr, 10'(off >> 2)});

        issues = 0; phase = 0; dly = rdy_dly; got = 0; busy_ok = 1; lat = 0;
        got_data = '0; got_pois = 0;
        for (int c = 0; c < 200 && !got; c++) begin
            @(negedge clk);
            req_valid = 1'b0;
            cc_valid = 1'b0;
            if (phase == 1) begin
                cq_ready = 1'b0;
                cc_valid = 1'b1;
                cc_status = (issues <= n_rrs) ? 2'd2 : fin_sts;
                cc_data = cdata;
                cc_poison = cpois;
                phase = 0;
            end else if (rsp_valid) begin
                got = 1; lat = c;
                got_data = rsp_rdata; got_pois = rsp_poison;
                if (req_ready) busy_ok = 0;
            end else if (cq_valid) begin
                if (req_ready) busy_ok = 0;
                if (dly > 0) begin
                    dly--;
                end else begin
                    check(cq_bus == 8'(bus) && cq_dev == 5'(dev) && cq_func == 3'(fn) &&
                          cq_reg == 10'(off >> 2) && cq_write == wr && (!wr || cq_wdata == wd),
                          {tag, " R1 request fields"}, {cq_bus, cq_dev, cq_func, cq_reg, 6'd0},
                          {8'(bus), 5'(dev), 3'(fn), 10'(off >> 2), 6'd0});
                    check(cq_type1 == (route == 3), {tag, " R2 R3 request type"},
                          {31'd0, cq_type1}, {31'd0, route == 3});
                    cq_ready = 1'b1;
                    phase = 1;
                    issues++;
                end
            end else if (req_ready) begin
                busy_ok = 0;
            end
        end
        cc_valid = 1'b0;
        check(got, {tag, " R11 response seen"}, {31'd0, got}, 32'd1);
        check(busy_ok, {tag, " R11 back-pressure while busy"}, {31'd0, busy_ok}, 32'd1);
        check(got_data == exp_data, {tag, " response data"}, got_data, exp_data);
        check(got_pois == exp_pois, {tag, " R9 poison flag"}, {31'd0, got_pois}, {31'd0, exp_pois});
        check(issues == exp_issues, {tag, " R10 issue count"}, issues, exp_issues);
        if (route < 2) check(lat == 0, {tag, " R5 local latency"}, lat, 0);
        @(negedge clk);
        check(!rsp_valid && req_ready, {tag, " R11 pulse and idle"}, {30'd0, rsp_valid, req_ready}, 32'd1);
        allow_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1 && cq_valid == 1'b0 && rsp_valid == 1'b0, "R12 reset state",
              {29'd0, req_ready, cq_valid, rsp_valid}, 32'h4);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1 && cq_valid == 1'b0 && rsp_valid == 1'b0, "R12 after reset",
              {29'd0, req_ready, cq_valid, rsp_valid}, 32'h4);

        xact(0, 1, 0, 2, 12'h010, 0, 0, 2'd0, 32'h1234_5678, 0, 0, "R2 type0 read");
        xact(1, 3, 7, 1, 12'h044, 32'hCAFE_0001, 0, 2'd0, 0, 0, 0, "R3 type1 write");
        xact(0, 4, 31, 7, 12'hFFC, 0, 0, 2'd0, 32'h0BAD_F00D, 0, 0, "R3 type1 top bus read");
        xact(0, 5, 0, 0, 12'h000, 0, 0, 2'd0, 0, 0, 0, "R5 out of range read");
        xact(1, 9, 2, 0, 12'h100, 32'h1111_2222, 0, 2'd0, 0, 0, 0, "R5 out of range write");
        xact(0, 1, 3, 0, 12'h000, 0, 0, 2'd0, 0, 0, 0, "R6 ari off read");
        xact(1, 1, 3, 0, 12'h004, 32'h3333_4444, 0, 2'd0, 0, 0, 0, "R6 ari off write");
        cfg_ari_fwd_en = 1'b1;
        xact(0, 1, 3, 4, 12'h008, 0, 0, 2'd0, 32'h5555_6666, 0, 0, "R6 ari on read");
        cfg_ari_fwd_en = 1'b0;
        xact(0, 1, 0, 0, 12'h012, 0, 0, 2'd0, 0, 0, 0, "R7 misaligned read");
        xact(1, 3, 0, 0, 12'h021, 32'h7777_8888, 0, 2'd0, 0, 0, 0, "R7 misaligned write");
        xact(0, 0, 0, 0, 12'h008, 0, 0, 2'd0, 0, 0, 0, "R4 own read");
        xact(1, 0, 0, 0, 12'h03C, 32'h9999_AAAA, 0, 2'd0, 0, 0, 0, "R4 own write");
        xact(0, 0, 2, 0, 12'h000, 0, 0, 2'd0, 0, 0, 0, "R4 missing primary function read");
        xact(1, 0, 0, 5, 12'h000, 32'hBBBB_CCCC, 0, 2'd0, 0, 0, 0, "R4 missing primary function write");
        xact(0, 2, 1, 0, 12'h000, 0, 0, 2'd1, 32'h1234_0000, 0, 0, "R8 unsupported read");
        xact(1, 2, 1, 0, 12'h000, 32'h0F0F_0F0F, 0, 2'd3, 0, 0, 0, "R8 abort write");
        xact(0, 1, 0, 0, 12'h000, 0, 0, 2'd3, 32'h4321_0000, 0, 0, "R8 abort read");
        xact(0, 1, 0, 1, 12'h040, 0, 0, 2'd0, 32'hDEAD_BEEF, 1, 0, "R9 poison forwarded");
        cfg_poison_fwd_dis = 1'b1;
        xact(0, 1, 0, 1, 12'h040, 0, 0, 2'd0, 32'hDEAD_BEEF, 1, 0, "R9 poison blocked");
        xact(0, 2, 0, 0, 12'h040, 0, 0, 2'd0, 32'h0000_00AB, 0, 0, "R9 clean data with block set");
        cfg_poison_fwd_dis = 1'b0;
        xact(0, 2, 0, 0, 12'h080, 0, 1, 2'd0, 32'hFACE_0001, 0, 0, "R10 one retry then data");
        xact(0, 2, 0, 0, 12'h080, 0, 2, 2'd0, 32'hFACE_0002, 0, 0, "R10 retries at limit");
        xact(0, 2, 0, 0, 12'h080, 0, 3, 2'd0, 32'hFACE_0003, 0, 0, "R10 retries exhausted read");
        xact(1, 3, 0, 0, 12'h080, 32'h0101_0202, 5, 2'd0, 0, 0, 0, "R10 retries exhausted write");
        cfg_retry_limit = 4'd0;
        xact(0, 1, 0, 0, 12'h000, 0, 1, 2'd0, 32'hFACE_0004, 0, 0, "R10 zero limit");
        cfg_retry_limit = 4'd2;
        xact(0, 4, 1, 1, 12'h0C0, 0, 0, 2'd0, 32'h2468_ACE0, 0, 4, "R11 slow requester");
        xact(0, 2, 0, 0, 12'h0C0, 0, 1, 2'd0, 32'h1357_9BDF, 1, 3, "R1 held request retried");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors + mon_errors);
        $finish;
    end

endmodule